// File: doc/BRIEF.md
# Dual-Bus Byte DMA Engine

This engine copies a programmed run of bytes between a wide-address memory bus (bus A) and a narrow peripheral-port bus (bus B). Each byte takes one fused transfer slot. In that slot the engine drives a bus A address and a bus B port address together, and it opens the read strobe on the source bus and the write strobe on the destination bus at the same moment. Only one data bus exists. The byte read from the source is steered straight onto the destination data output with no register between them, and it stays driven while the destination accepts the write.

Software sets up four values through a small register-style port: the starting A address, the B port number, the byte count and the direction. It then pulses `start`. The engine raises `busy` for the whole run. The A address steps by one after every byte and the B port stays fixed. One memory is mapped on both buses: a window of A addresses plus one B port. The engine never selects that memory on both buses in the same slot. A byte whose two addresses both land on that memory gets no strobes and no output enable, although its slot time and its address step still happen.

The state machine has five states. ST_IDLE waits for `start`. ST_ADDR covers slot clocks 0–2, when the addresses settle. ST_STROBE covers clocks 3–6, when the strobes are active. ST_HOLD is clock 7, when the strobes are released and the data stays driven. ST_DONE is the single cycle after the last slot. The transitions are:
- IDLE→ADDR on `start`.
- ADDR→STROBE after clock 2.
- STROBE→HOLD after clock 6.
- HOLD→ADDR when bytes remain, and HOLD→DONE after the last byte.
- DONE→IDLE always.

Top module: `dbdma_engine`

## Requirements
- R1: Each byte occupies exactly 8 clock cycles. `busy` is high for exactly 8×N cycles, starting in the cycle after the edge that samples `start`.
- R2: Throughout every slot, `a_addr` holds the address of the current byte and `b_addr` holds the latched B port.
- R3: Strobes are high in slot clocks 3 to 6 and low in clocks 0 to 2 and 7. The destination output enable is high in clocks 3 to 7, so it lasts one clock past the write strobe.
- R4: Direction value 0 (A to B) drives `a_rd` and `b_wr` together. Direction value 1 (B to A) drives `b_rd` and `a_wr` together. The other two strobes stay low.
- R5: The destination data output equals the source data input in the same cycle, with no register between them. The single shared data bus carries `a_din` in A-to-B mode and `b_din` in B-to-A mode, and both `a_dout` and `b_dout` show it.
- R6: A byte whose A address satisfies (`a_addr` & 0xFE0000) == 0x7E0000 while the B port is 0x80 gets no strobe and no output enable on either bus. Its slot still takes 8 clocks and still advances the address.
- R7: The A address increases by one after every byte and wraps at its width. The B port never changes during a run. After the run, `a_addr` shows the start address plus N.
- R8: A count of zero transfers 2^CNT_W bytes.
- R9: `done` is high for exactly one cycle, the cycle after the last slot, and `busy` is low in that cycle.
- R10: A `start` pulse is ignored while `busy` or `done` is high. Writes to the setup port during a run do not affect that run.
- R11: During and right after reset, `busy`, `done`, all four strobes and both output enables are low.
- R12: Setup port select codes are 0 for the A address, 1 for the B port (low B_W bits), 2 for the count (low CNT_W bits) and 3 for the direction (bit 0). The values are copied at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup register write enable |
| cfg_sel | input | 2 | Setup register select (0 A address, 1 B port, 2 count, 3 direction) |
| cfg_wdata | input | A_W | Setup write data |
| start | input | 1 | Start strobe, sampled only in idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | A_W | Bus A address |
| a_rd | output | 1 | Bus A read strobe |
| a_wr | output | 1 | Bus A write strobe |
| a_din | input | D_W | Data driven onto the shared bus by a bus A source |
| a_dout | output | D_W | Shared bus value presented to bus A |
| a_doe | output | 1 | Bus A destination data enable |
| b_addr | output | B_W | Bus B port address |
| b_rd | output | 1 | Bus B read strobe |
| b_wr | output | 1 | Bus B write strobe |
| b_din | input | D_W | Data driven onto the shared bus by a bus B source |
| b_dout | output | D_W | Shared bus value presented to bus B |
| b_doe | output | 1 | Bus B destination data enable |

## Verification
Two functions can fall in the same cycle. The end of a slot, when the address steps and the remaining count drops, can coincide with the shared-memory guard changing its decision. The bench starts a run at A address 0x7DFFFF with port 0x80, so the step into 0x7E0000 switches the second byte into a suppressed slot. It checks that the first byte strobes normally and the second shows no strobes or output enables while still taking its 8 clocks. A start pulse is also sent in the middle of a slot and in the `done` cycle, together with a setup write. The checks confirm that neither disturbs the addresses, the length or the single `done` pulse of the run already in flight.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

    // Slot layout in master clocks
    localparam int SLOT_CLOCKS = 8;
    localparam int STROBE_ON   = 3;   // first clock with strobes high
    localparam int STROBE_OFF  = 7;   // first clock with strobes low again

    // Setup port select codes
    localparam logic [1:0] SEL_A_ADDR = 2'd0;
    localparam logic [1:0] SEL_B_PORT = 2'd1;
    localparam logic [1:0] SEL_COUNT  = 2'd2;
    localparam logic [1:0] SEL_DIR    = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4
    } dma_state_t;

endpackage

// File: rtl/dbdma_slot_timer.sv
module dbdma_slot_timer #(
    parameter int PHASES = 8,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Each running clock advances the slot position by one
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(phase) != LAST) |-> (phase == PH_W'($past(phase) + 1'b1)));

    // Within a run the position wraps to zero after the last clock
    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(phase) == LAST) |-> (phase == '0));

endmodule

// File: rtl/dbdma_addr_gen.sv
module dbdma_addr_gen #(
    parameter int A_W   = 24,
    parameter int CNT_W = 16,
    parameter int REM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [A_W-1:0]   load_addr,
    input  logic [CNT_W-1:0] load_count,
    output logic [A_W-1:0]   addr,
    output logic             last_byte
);
    localparam logic [REM_W-1:0] FULL_RUN = REM_W'(1) << CNT_W;

    logic [REM_W-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= load_addr;
            remaining <= (load_count == '0) ? FULL_RUN : REM_W'(load_count);
        end else if (step) begin
            addr      <= addr + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last_byte = (remaining == REM_W'(1));

    // A step moves the address by exactly one, wrapping at its width
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step) && !$past(load)) |-> (addr == A_W'($past(addr) + 1'b1)));

    // A zero count loads the full-range run length
    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && $past(load_count) == '0) |-> (remaining == FULL_RUN));

endmodule

// File: rtl/dbdma_guard.sv
module dbdma_guard #(
    parameter int             A_W    = 24,
    parameter int             B_W    = 8,
    parameter logic [A_W-1:0] A_BASE = 24'h7E0000,
    parameter logic [A_W-1:0] A_MASK = 24'hFE0000,
    parameter logic [B_W-1:0] B_PORT = 8'h80
) (
    input  logic [A_W-1:0] a_addr,
    input  logic [B_W-1:0] b_addr,
    output logic           clash
);
    logic a_hits_shared;
    logic b_hits_shared;

    always_comb begin
        a_hits_shared = ((a_addr & A_MASK) == A_BASE);
        b_hits_shared = (b_addr == B_PORT);
        clash         = a_hits_shared && b_hits_shared;
    end

endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
    import dbdma_pkg::*;
#(
    parameter int             A_W           = 24,
    parameter int             B_W           = 8,
    parameter int             CNT_W         = 16,
    parameter int             D_W           = 8,
    parameter logic [A_W-1:0] SHARED_A_BASE = 24'h7E0000,
    parameter logic [A_W-1:0] SHARED_A_MASK = 24'hFE0000,
    parameter logic [B_W-1:0] SHARED_B_PORT = 8'h80
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [A_W-1:0] cfg_wdata,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic [A_W-1:0] a_addr,
    output logic           a_rd,
    output logic           a_wr,
    input  logic [D_W-1:0] a_din,
    output logic [D_W-1:0] a_dout,
    output logic           a_doe,
    output logic [B_W-1:0] b_addr,
    output logic           b_rd,
    output logic           b_wr,
    input  logic [D_W-1:0] b_din,
    output logic [D_W-1:0] b_dout,
    output logic           b_doe
);
    localparam int PH_W = $clog2(SLOT_CLOCKS);
    localparam logic [PH_W-1:0] PH_LAST_ADDR   = PH_W'(STROBE_ON - 1);
    localparam logic [PH_W-1:0] PH_LAST_STROBE = PH_W'(STROBE_OFF - 1);

    // Setup shadow registers, copied into the working set at start
    logic [A_W-1:0]   cfg_a_addr;
    logic [B_W-1:0]   cfg_b_port;
    logic [CNT_W-1:0] cfg_count;
    logic             cfg_dir;

    // Working set for the run in flight
    logic [B_W-1:0]   run_b_port;
    logic             run_dir;

    dma_state_t       state, state_nx;
    logic [PH_W-1:0]  phase;
    logic             running;
    logic             accept;
    logic             slot_end;
    logic             last_byte;
    logic             clash;
    logic             strobe_win;
    logic             hold_win;
    logic [D_W-1:0]   shared_bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a_addr <= '0;
            cfg_b_port <= '0;
            cfg_count  <= '0;
            cfg_dir    <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_A_ADDR: cfg_a_addr <= cfg_wdata;
                SEL_B_PORT: cfg_b_port <= cfg_wdata[B_W-1:0];
                SEL_COUNT:  cfg_count  <= cfg_wdata[CNT_W-1:0];
                SEL_DIR:    cfg_dir    <= cfg_wdata[0];
                default:    cfg_dir    <= cfg_dir;
            endcase
        end
    end

    assign accept   = (state == ST_IDLE) && start;
    assign slot_end = (state == ST_HOLD);
    assign running  = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_b_port <= '0;
            run_dir    <= 1'b0;
        end else if (accept) begin
            run_b_port <= cfg_b_port;
            run_dir    <= cfg_dir;
        end
    end

    dbdma_slot_timer #(
        .PHASES (SLOT_CLOCKS),
        .PH_W   (PH_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .phase (phase)
    );

    dbdma_addr_gen #(
        .A_W   (A_W),
        .CNT_W (CNT_W),
        .REM_W (CNT_W + 1)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .step       (slot_end),
        .load_addr  (cfg_a_addr),
        .load_count (cfg_count),
        .addr       (a_addr),
        .last_byte  (last_byte)
    );

    dbdma_guard #(
        .A_W    (A_W),
        .B_W    (B_W),
        .A_BASE (SHARED_A_BASE),
        .A_MASK (SHARED_A_MASK),
        .B_PORT (SHARED_B_PORT)
    ) u_guard (
        .a_addr (a_addr),
        .b_addr (run_b_port),
        .clash  (clash)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ADDR;
            ST_ADDR:   if (phase == PH_LAST_ADDR) state_nx = ST_STROBE;
            ST_STROBE: if (phase == PH_LAST_STROBE) state_nx = ST_HOLD;
            ST_HOLD:   state_nx = last_byte ? ST_DONE : ST_ADDR;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = running;
        done       = (state == ST_DONE);
        strobe_win = (state == ST_STROBE) && !clash;
        hold_win   = ((state == ST_STROBE) || (state == ST_HOLD)) && !clash;
        a_rd       = strobe_win && !run_dir;
        b_wr       = strobe_win && !run_dir;
        b_rd       = strobe_win && run_dir;
        a_wr       = strobe_win && run_dir;
        b_doe      = hold_win && !run_dir;
        a_doe      = hold_win && run_dir;
        shared_bus = run_dir ? b_din : a_din;
        a_dout     = shared_bus;
        b_dout     = shared_bus;
        b_addr     = run_b_port;
    end

    // ---------------- assertions ----------------
    assert_strobe_pair_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |-> (b_wr && !a_wr && !b_rd));

    assert_strobe_pair_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd |-> (a_wr && !b_wr && !a_rd));

    assert_data_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_wr) |-> b_doe);

    assert_data_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_wr) |-> a_doe);

    assert_strobe_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd || a_wr || b_rd || b_wr || a_doe || b_doe) |-> busy);

    assert_no_dual_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd || a_wr || b_rd || b_wr) |->
            !(((a_addr & SHARED_A_MASK) == SHARED_A_BASE) && (b_addr == SHARED_B_PORT)));

    assert_port_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(b_addr));

    assert_addr_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(slot_end)) |-> $stable(a_addr));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/dbdma_engine_bench.sv
module dbdma_engine_bench;
    localparam int A_W = 24;
    localparam int B_W = 8;
    localparam int CNT_W = 8;
    localparam int D_W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [A_W-1:0] cfg_wdata = '0;
    logic           start = 1'b0;
    logic           busy, done;
    logic [A_W-1:0] a_addr;
    logic           a_rd, a_wr, a_doe, b_rd, b_wr, b_doe;
    logic [D_W-1:0] a_din = '0, b_din = '0, a_dout, b_dout;
    logic [B_W-1:0] b_addr;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;  // 125 MHz

    dbdma_engine #(.A_W(A_W), .B_W(B_W), .CNT_W(CNT_W), .D_W(D_W)) u_dbdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .busy(busy), .done(done),
        .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_din(a_din), .a_dout(a_dout), .a_doe(a_doe),
        .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_din(b_din), .b_dout(b_dout), .b_doe(b_doe));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit shared_hit(input logic [A_W-1:0] a, input logic [B_W-1:0] p);
        return ((a & 24'hFE0000) == 24'h7E0000) && (p == 8'h80);
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [A_W-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one transfer and checks every clock of every slot.
    // inject: pulse start plus a setup write mid-run and in the done cycle (R10)
    task automatic run_xfer(input logic [A_W-1:0] a0, input logic [B_W-1:0] port,
                            input int n, input bit dir, input bit inject);
        logic [A_W-1:0] exp_a;
        logic [9:0] act_v, exp_v;
        bit g, sw, ow;
        cfg_write(2'd0, a0);        // R12 select codes
        cfg_write(2'd1, A_W'(port));
        cfg_write(2'd2, A_W'(n % 256));
        cfg_write(2'd3, A_W'(dir));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_a = a0 + A_W'(i);
            g = shared_hit(exp_a, port);
            for (int p = 0; p < 8; p++) begin
                sw = (p >= 3 && p <= 6) && !g;
                ow = (p >= 3) && !g;
                act_v = {busy, done, a_rd, a_wr, b_rd, b_wr, a_doe, b_doe, 2'b00};
                exp_v = {1'b1, 1'b0, sw && !dir, sw && dir, sw && dir, sw && !dir,
                         ow && dir, ow && !dir, 2'b00};
                check(act_v == exp_v, "R1/R3/R4/R6 slot strobes", 64'(act_v), 64'(exp_v));
                check(a_addr == exp_a && b_addr == port, "R2/R7 addresses",
                      64'({a_addr, b_addr}), 64'({exp_a, port}));
                if (p == 4) begin
                    a_din = 8'hA0 ^ 8'(i);
                    b_din = 8'h5C ^ 8'(i);
                    #1;
                    check((dir ? a_dout : b_dout) == (dir ? b_din : a_din), "R5 same-cycle data",
                          64'(dir ? a_dout : b_dout), 64'(dir ? b_din : a_din));
                end
                if (inject && i == 0 && p == 2) begin
                    start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 24'h000111;
                end
                if (inject && i == 0 && p == 3) begin
                    start = 1'b0; cfg_we = 1'b0;
                end
                @(negedge clk);
            end
        end
        check(done == 1'b1 && busy == 1'b0, "R9 done pulse", 64'({done, busy}), 64'(2'b10));
        check(a_addr == a0 + A_W'(n), "R7 final address", 64'(a_addr), 64'(a0 + A_W'(n)));
        if (inject) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && busy == 1'b0, "R9/R10 after done", 64'({done, busy}), 64'(2'b00));
        @(negedge clk);
        check(busy == 1'b0, "R10 start in done ignored", 64'(busy), 64'(0));
    endtask

    task automatic test_reset();
        check({busy, done, a_rd, a_wr, b_rd, b_wr, a_doe, b_doe} == 8'h00, "R11 reset outputs",
              64'({busy, done, a_rd, a_wr, b_rd, b_wr, a_doe, b_doe}), 64'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_xfer(24'h123456, 8'h18, 3, 1'b0, 1'b0);   // R4 A to B
        run_xfer(24'h0A0010, 8'h22, 2, 1'b1, 1'b0);   // R4 B to A
        run_xfer(24'h7DFFFF, 8'h80, 2, 1'b0, 1'b0);   // R6 guard boundary
        run_xfer(24'h7E0010, 8'h81, 1, 1'b1, 1'b0);   // R6 other port not guarded
        run_xfer(24'hFFFFFF, 8'h30, 2, 1'b0, 1'b0);   // R7 wrap
        run_xfer(24'h004000, 8'h40, 4, 1'b0, 1'b1);   // R10 start during run
        run_xfer(24'h00FFF0, 8'h44, 256, 1'b1, 1'b0); // R8 zero count
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule